// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit sits behind a serial memory slave and owns the write-protection state of a byte-addressed nonvolatile array. It keeps a write enable latch plus three protection settings (a status-lock enable and a two-bit block-protect code). From these, the current target address and an active-low hardware lock pin, it decides, every cycle, whether a memory byte write and whether a status byte write may proceed.

The slave front end hands over single-cycle strobes: enable-writes, disable-writes, a fully received status data byte, and the end of a write-type command (chip select rising after a memory write or a status write). The unit returns the assembled status byte for status reads. The nonvolatile protection settings are plain registers here, loaded at reset from a parameter.

Top module: `wp_status_unit`

## Requirements
- R1: The status byte has bit 7 = lock enable (WPEN), bit 3 = BP1, bit 2 = BP0, bit 1 = write enable latch (WEL), and bits 6..4 and 0 read as 0 at all times. After reset WEL is 0 and WPEN/BP1/BP0 equal the INIT_CFG parameter (default 0), so the status byte reads 8'h00.
- R2: A `wren_pulse` sets WEL, visible in the status byte one clock later.
- R3: A `wrdi_pulse` clears WEL one clock later; when any clear source coincides with `wren_pulse`, the clear wins.
- R4: A `wr_end_pulse` (end of a memory write or status write command, whether or not it was permitted) clears WEL one clock later; WEL stays set across the bytes of a burst until then.
- R5: A `wrsr_pulse` while the status write permit is high loads data bits 7, 3 and 2 into WPEN, BP1, BP0 one clock later; data bits 6..4, 1 and 0 have no effect, and WEL is unchanged by the load.
- R6: A `wrsr_pulse` while the status write permit is low leaves WPEN, BP1 and BP0 unchanged.
- R7: With WEL set, `mem_wr_ok` is low exactly when the address lies in the protected range of the BP code: 00 none, 01 1800h-1FFFh, 10 1000h-1FFFh, 11 the whole array; the permit follows the address and state in the same cycle.
- R8: With WEL clear, both `mem_wr_ok` and `sr_wr_ok` are low.
- R9: With WEL set, `sr_wr_ok` is low exactly when WPEN is 1 and `wp_n` is 0; `wp_n` never affects `mem_wr_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wren_pulse | input | 1 | Enable-writes command decoded |
| wrdi_pulse | input | 1 | Disable-writes command decoded |
| wrsr_pulse | input | 1 | Status data byte fully received |
| wrsr_data | input | 8 | Received status data byte |
| wr_end_pulse | input | 1 | Chip select rose after a write-type command |
| addr | input | 13 | Current memory target address |
| wp_n | input | 1 | Hardware status lock pin, active low |
| status_byte | output | 8 | Assembled status byte |
| mem_wr_ok | output | 1 | Memory byte write permitted |
| sr_wr_ok | output | 1 | Status byte write permitted |

## Verification
The bench hits the protection range edges (17FFh/1800h, 0FFFh/1000h, 0000h) under every block code; an off-by-one range decode would grant or refuse a write at exactly one of those addresses. It drives enable and clear strobes in the same cycle, where a design with the wrong priority would leave writes enabled after a command end, and writes all-ones status data to catch fixed bits or the latch being altered by the load. It also locks the status register with the pin and confirms the memory permit is untouched, which a design gating memory by the pin would fail.

// File: rtl/wp_pkg.sv
// Package: shared widths, status bit positions and the protection config type.
package wp_pkg;
    localparam int STAT_W    = 8;
    localparam int BIT_WPEN  = 7;
    localparam int BIT_BP1   = 3;
    localparam int BIT_BP0   = 2;
    localparam int BIT_WEL   = 1;

    // Nonvolatile protection settings.
    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } prot_cfg_t;

    // Block-protect codes.
    localparam logic [1:0] BP_NONE    = 2'b00;
    localparam logic [1:0] BP_QUARTER = 2'b01;
    localparam logic [1:0] BP_HALF    = 2'b10;
    localparam logic [1:0] BP_ALL     = 2'b11;
endpackage

// File: rtl/wp_wel_latch.sv
// Module: wp_wel_latch
// Holds the write enable latch. Set by set_i, cleared by any clear source;
// clear has priority. Assumes strobes are single-cycle and synchronous.
module wp_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    // Latch update with clear taking priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)      wel_o <= 1'b0;
        else if (clr_i)  wel_o <= 1'b0;
        else if (set_i)  wel_o <= 1'b1;
    end
endmodule

// File: rtl/wp_cfg_regs.sv
// Module: wp_cfg_regs
// Holds WPEN/BP1/BP0, standing in for nonvolatile cells. Loads the writable
// fields from a status data byte when load_i is high; other bits are dropped.
// Assumes load_i is already qualified by the status write permit.
module wp_cfg_regs
    import wp_pkg::*;
#(
    parameter logic [2:0] INIT_CFG = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [STAT_W-1:0] data_i,
    output prot_cfg_t         cfg_o
);
    prot_cfg_t init_val;
    prot_cfg_t load_val;

    // Map the parameter and the incoming byte onto the config fields.
    always_comb begin
        init_val = prot_cfg_t'(INIT_CFG);
        load_val.wpen = data_i[BIT_WPEN];
        load_val.bp   = {data_i[BIT_BP1], data_i[BIT_BP0]};
    end

    // Config register: reset to the initial value, load on permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_o <= init_val;
        else if (load_i) cfg_o <= load_val;
    end
endmodule

// File: rtl/wp_block_decode.sv
// Module: wp_block_decode
// Decides whether an address falls in the range a block-protect code
// covers: none, top quarter, top half or everything. Purely combinational.
module wp_block_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    localparam int TOP = ADDR_W - 1;

    logic in_quarter;
    logic in_half;

    // Region flags from the top address bits.
    always_comb begin
        in_quarter = addr_i[TOP] & addr_i[TOP-1];
        in_half    = addr_i[TOP];
    end

    // Select the protection result for the current code.
    always_comb begin
        unique case (bp_i)
            BP_NONE:    prot_o = 1'b0;
            BP_QUARTER: prot_o = in_quarter;
            BP_HALF:    prot_o = in_half;
            default:    prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_status_unit.sv
// Module: wp_status_unit (top)
// Write-protection unit for a serial nonvolatile memory. Combines the write
// enable latch, the protection config and the address range decode into a
// status byte and two write permits. Assumes command strobes come from a
// slave that has already decoded opcodes and framed bytes.
module wp_status_unit
    import wp_pkg::*;
#(
    parameter int         ADDR_W   = 13,
    parameter logic [2:0] INIT_CFG = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_pulse,
    input  logic              wrdi_pulse,
    input  logic              wrsr_pulse,
    input  logic [STAT_W-1:0] wrsr_data,
    input  logic              wr_end_pulse,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_n,
    output logic [STAT_W-1:0] status_byte,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    logic      wel;
    logic      blk_prot;
    logic      pin_lock;
    logic      cfg_load;
    prot_cfg_t cfg;

    wp_wel_latch i_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wren_pulse),
        .clr_i (wrdi_pulse | wr_end_pulse),
        .wel_o (wel)
    );

    wp_cfg_regs #(.INIT_CFG(INIT_CFG)) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load),
        .data_i (wrsr_data),
        .cfg_o  (cfg)
    );

    wp_block_decode #(.ADDR_W(ADDR_W)) i_dec (
        .bp_i   (cfg.bp),
        .addr_i (addr),
        .prot_o (blk_prot)
    );

    // Permit logic: latch gates both, pin gates only the status register.
    always_comb begin
        pin_lock  = cfg.wpen & ~wp_n;
        sr_wr_ok  = wel & ~pin_lock;
        mem_wr_ok = wel & ~blk_prot;
        cfg_load  = wrsr_pulse & sr_wr_ok;
    end

    // Status byte assembly with fixed-zero positions.
    always_comb begin
        status_byte           = '0;
        status_byte[BIT_WPEN] = cfg.wpen;
        status_byte[BIT_BP1]  = cfg.bp[1];
        status_byte[BIT_BP0]  = cfg.bp[0];
        status_byte[BIT_WEL]  = wel;
    end
endmodule

// File: rtl/wp_status_unit_chk.sv
// Module: wp_status_unit_chk
// Port-level properties of wp_status_unit, bound to every instance.
module wp_status_unit_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wren_pulse,
    input logic              wrdi_pulse,
    input logic              wrsr_pulse,
    input logic              wr_end_pulse,
    input logic [ADDR_W-1:0] addr,
    input logic              wp_n,
    input logic [7:0]        status_byte,
    input logic              mem_wr_ok,
    input logic              sr_wr_ok
);
    assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_pulse && !wrdi_pulse && !wr_end_pulse) |=> status_byte[1]);

    assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi_pulse |=> !status_byte[1]);

    assert_end_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end_pulse |=> !status_byte[1]);

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrsr_pulse && sr_wr_ok) |=> $stable({status_byte[7], status_byte[3:2]}));

    assert_all_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_wr_ok);

    assert_no_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[1] |-> (!mem_wr_ok && !sr_wr_ok));

    assert_pin_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !wp_n) |-> !sr_wr_ok);
endmodule

bind wp_status_unit wp_status_unit_chk #(.ADDR_W(ADDR_W)) i_wp_status_unit_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wren_pulse   (wren_pulse),
    .wrdi_pulse   (wrdi_pulse),
    .wrsr_pulse   (wrsr_pulse),
    .wr_end_pulse (wr_end_pulse),
    .addr         (addr),
    .wp_n         (wp_n),
    .status_byte  (status_byte),
    .mem_wr_ok    (mem_wr_ok),
    .sr_wr_ok     (sr_wr_ok)
);

// File: tb/test_wp_status_unit.sv
module test_wp_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_pulse = 1'b0, wrdi_pulse = 1'b0, wrsr_pulse = 1'b0, wr_end_pulse = 1'b0;
    logic [7:0]  wrsr_data = '0;
    logic [12:0] addr = '0;
    logic        wp_n = 1'b1;
    logic [7:0]  status_byte;
    logic        mem_wr_ok, sr_wr_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state
    logic       m_wel = 0, m_wpen = 0;
    logic [1:0] m_bp = 0;

    always #2 clk = ~clk;

    wp_status_unit i_wp_status_unit (
        .clk(clk), .rst_n(rst_n), .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse),
        .wrsr_pulse(wrsr_pulse), .wrsr_data(wrsr_data), .wr_end_pulse(wr_end_pulse),
        .addr(addr), .wp_n(wp_n), .status_byte(status_byte),
        .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    function automatic logic in_range(input logic [1:0] bp, input logic [12:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'h1800;
            2'b10:   return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic exp_sr_ok();
        return m_wel && !(m_wpen && !wp_n);
    endfunction

    function automatic logic exp_mem_ok();
        return m_wel && !in_range(m_bp, addr);
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply inputs for one cycle: check permits before the edge, state after.
    task automatic step(input logic wren, input logic wrdi, input logic wrsr,
                        input logic [7:0] d, input logic wend,
                        input logic [12:0] a, input logic pin, input string tag);
        logic sr_now;
        wren_pulse = wren; wrdi_pulse = wrdi; wrsr_pulse = wrsr;
        wrsr_data = d; wr_end_pulse = wend; addr = a; wp_n = pin;
        #1;
        chk({tag, " R7 mem permit"}, {7'b0, mem_wr_ok}, {7'b0, exp_mem_ok()});
        chk({tag, " R9 status permit"}, {7'b0, sr_wr_ok}, {7'b0, exp_sr_ok()});
        sr_now = exp_sr_ok();
        if (wrsr && sr_now) begin
            m_wpen = d[7];
            m_bp   = d[3:2];
        end
        if (wrdi || wend) m_wel = 1'b0;
        else if (wren)    m_wel = 1'b1;
        @(posedge clk);
        #1;
        wren_pulse = 0; wrdi_pulse = 0; wrsr_pulse = 0; wr_end_pulse = 0;
        chk({tag, " R5 status"}, status_byte, exp_status());
    endtask

    task automatic idle_probe(input logic [12:0] a, input logic pin, input logic exp_mem,
                              input logic exp_sr, input string tag);
        addr = a; wp_n = pin;
        #1;
        chk(tag, {6'b0, mem_wr_ok, sr_wr_ok}, {6'b0, exp_mem, exp_sr});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset value
        chk("R1 reset status", status_byte, 8'h00);
        idle_probe(13'h0000, 1'b1, 1'b0, 1'b0, "R8 permits with WEL clear");

        step(1, 0, 0, 8'h00, 0, 13'h0, 1, "R2 wren");
        chk("R2 WEL set", {7'b0, status_byte[1]}, 8'h01);
        step(1, 1, 0, 8'h00, 0, 13'h0, 1, "R3 wren+wrdi");
        chk("R3 clear wins", {7'b0, status_byte[1]}, 8'h00);
        step(1, 0, 0, 8'h00, 0, 13'h0, 1, "R2 wren again");
        step(1, 0, 0, 8'h00, 1, 13'h0, 1, "R4 wren+end");
        chk("R4 end clears", {7'b0, status_byte[1]}, 8'h00);

        // R5: load with data bit1 clear keeps WEL; all-ones sets only writable bits
        step(1, 0, 0, 8'h00, 0, 13'h0, 1, "R5 prep");
        step(0, 0, 1, 8'h00, 0, 13'h0, 1, "R5 zero load");
        chk("R5 WEL kept", status_byte, 8'h02);
        step(0, 0, 1, 8'hFF, 0, 13'h0, 1, "R5 ones load");
        chk("R5 fixed bits", status_byte, 8'h8E);
        step(0, 0, 0, 8'h00, 1, 13'h0, 1, "R4 end of status write");
        chk("R4 WEL after end", status_byte, 8'h8C);

        // R6: pin locks, WRSR ignored
        step(1, 0, 0, 8'h00, 0, 13'h0, 0, "R6 prep");
        step(0, 0, 1, 8'h00, 0, 13'h0, 0, "R6 locked load");
        chk("R6 unchanged", status_byte, 8'h8E);
        idle_probe(13'h0000, 1'b0, 1'b0, 1'b0, "R7 all protected");
        step(0, 0, 0, 8'h00, 1, 13'h0, 0, "R6 end");
        chk("R6 latch cleared", status_byte, 8'h8C);

        // R7/R9: range edges per code; pin low never blocks memory
        for (int c = 0; c < 4; c++) begin
            step(1, 0, 0, 8'h00, 0, 13'h0, 1, "R7 wren");
            step(0, 0, 1, {1'b1, 3'b000, c[1:0], 2'b00}, 0, 13'h0, 1, "R7 set code");
            step(1, 0, 0, 8'h00, 1, 13'h0, 1, "R7 end then wren");
            step(1, 0, 0, 8'h00, 0, 13'h0, 1, "R7 wren");
            step(0, 0, 0, 8'h00, 0, 13'h17FF, 0, "R9 pin low 17FF");
            step(0, 0, 0, 8'h00, 0, 13'h1800, 0, "R9 pin low 1800");
            step(0, 0, 0, 8'h00, 0, 13'h0FFF, 1, "R7 0FFF");
            step(0, 0, 0, 8'h00, 0, 13'h1000, 1, "R7 1000");
            step(0, 0, 0, 8'h00, 0, 13'h0000, 1, "R7 0000");
            step(0, 0, 0, 8'h00, 0, 13'h1FFF, 1, "R7 1FFF");
            step(0, 0, 0, 8'h00, 1, 13'h0, 1, "R4 end");
        end
        // R9: WPEN clear means pin ignored
        step(1, 0, 0, 8'h00, 0, 13'h0, 1, "R9 wren");
        step(0, 0, 1, 8'h00, 0, 13'h0, 1, "R9 clear wpen");
        step(0, 0, 0, 8'h00, 0, 13'h0, 0, "R9 pin ignored");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
                 8'($urandom), ($urandom % 6) == 0, 13'($urandom), r[0] | r[1],
                 "rand");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule